// File: doc/BRIEF.md
# Minute-Second Countdown Watchdog

This block is a watchdog timer seen by a host as a 256-byte register window. The host reaches it through an 8-bit offset, a write strobe, a read strobe and byte-wide data paths. The time left is kept in two bytes: one holds whole minutes and the other holds seconds in the range 0 to 59. While the timer runs, the pair counts down once per second as a single mixed-radix value. When the seconds byte wraps from 0 to 59, one is borrowed from the minutes byte.

A timeout of T seconds is loaded by writing T/60 to the minutes byte and T mod 60 to the seconds byte. The countdown starts when 1 is written to the control byte. To keep the system alive, the host rewrites both time bytes and writes 1 to the control byte again; this restarts the count from the new value. If the count runs out, the block drives a reset output for a fixed number of cycles and then stops itself. An internal prescaler divides the system clock into a one-second tick. The window also holds a three-byte read-only vendor tag.

Top module: `mmss_watchdog`

## Requirements
- R1: After reset the control byte reads 0x00, minutes read 1, seconds read 0, and `wdt_rst_o` is low.
- R2: Offset 0x06 is the control byte. Bit 0 of a write sets (1) or clears (0) the run state, and writing 1 restarts the prescaler. A read returns the run state in bit 0 with the other bits zero.
- R3: Offset 0x07 is the minutes byte, a full 8-bit register that can be read and written. Offset 0x08 is the seconds byte. A write of a value above 59 to the seconds byte is stored as 59.
- R4: A read is registered. The byte at `addr_i` appears on `rdata_o` one cycle after `rd_i` is sampled high, and `rdata_o` keeps its value in any cycle where `rd_i` is low.
- R5: While running, minutes*60+seconds drops by one every CLK_PER_SEC cycles. The first drop takes effect CLK_PER_SEC cycles after the edge that wrote 1 to the control byte. When seconds is 0, it becomes 59 and minutes drops by one.
- R6: While stopped, the time bytes hold their values and `wdt_rst_o` stays low.
- R7: For a programmed time T >= 1, `wdt_rst_o` rises T*CLK_PER_SEC cycles after the enabling write. A programmed time of 0:00 fires after CLK_PER_SEC cycles. The output stays high for exactly RST_CYC cycles, and the run state reads 0 afterwards.
- R8: If the time bytes are rewritten and 1 is written to the control byte before expiry, the count restarts from the new value with no reset pulse in between.
- R9: Offsets 0x4D, 0x4E and 0x4F read 0x50, 0x57 and 0x47 ('P', 'W', 'G'). Writes to them change nothing.
- R10: Every other offset reads 0x00, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register offset |
| wr_i | input | 1 | Write strobe, one byte per high cycle |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| wdt_rst_o | output | 1 | Reset request on expiry |

## Verification
The pulse-width assertion assumes that the host does not re-arm the timer with 0:00 while a reset pulse is still in progress. If that happened, a second expiry could stretch the pulse. The stimulus always waits for the pulse to fall before it programs the next timeout. The single-step decrement property only covers ticks in a cycle with no host write to the time bytes, because such a write takes priority. The stimulus keeps its mid-count accesses to reads, except in the keepalive sequence, where the check is instead the exact arrival time of the reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h06;
  localparam logic [7:0] OFS_MIN  = 8'h07;
  localparam logic [7:0] OFS_SEC  = 8'h08;
  localparam logic [7:0] OFS_TAG  = 8'h4D;
  localparam int unsigned TAG_LEN = 3;
  localparam logic [7:0] SEC_TOP  = 8'd59;

  function automatic logic [7:0] tag_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h50;
      2'd1:    return 8'h57;
      2'd2:    return 8'h47;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned CLK_PER_SEC = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (cnt_q == LAST)      cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/wdt_mmss_cnt.sv
module wdt_mmss_cnt
  import wdt_pkg::*;
#(
  parameter logic [7:0] INIT_MIN = 8'd1,
  parameter logic [7:0] INIT_SEC = 8'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_min_i,
  input  logic       wr_sec_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] min_o,
  output logic [7:0] sec_o,
  output logic       expire_o
);
  logic [7:0] min_q, sec_q;
  logic       host_wr;

  assign host_wr = wr_min_i || wr_sec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= INIT_MIN;
      sec_q <= INIT_SEC;
    end else if (host_wr) begin
      if (wr_min_i) min_q <= wdata_i;
      if (wr_sec_i) sec_q <= (wdata_i > SEC_TOP) ? SEC_TOP : wdata_i;
    end else if (tick_i) begin
      if (sec_q != 8'd0) begin
        sec_q <= sec_q - 8'd1;
      end else if (min_q != 8'd0) begin
        sec_q <= SEC_TOP;
        min_q <= min_q - 8'd1;
      end
    end
  end

  // expire on the tick that reaches 0:00, or any tick already at 0:00
  assign expire_o = tick_i && !host_wr && (min_q == 8'd0) && (sec_q <= 8'd1);
  assign min_o    = min_q;
  assign sec_o    = sec_q;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_o
);
  localparam int unsigned PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fire_i)        cnt_q <= PW'(RST_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = (cnt_q != '0);
endmodule

// File: rtl/mmss_watchdog.sv
module mmss_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_PER_SEC = 50_000_000,
  parameter int unsigned RST_CYC     = 16,
  parameter logic [7:0]  INIT_MIN    = 8'd1,
  parameter logic [7:0]  INIT_SEC    = 8'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       wdt_rst_o
);
  logic       en_q;
  logic       wr_ctrl, wr_min, wr_sec, restart;
  logic       tick, expire;
  logic [7:0] min_val, sec_val;
  logic [7:0] rmux, rdata_q;
  logic [7:0] tag_ofs;

  assign wr_ctrl = wr_i && (addr_i == OFS_CTRL);
  assign wr_min  = wr_i && (addr_i == OFS_MIN);
  assign wr_sec  = wr_i && (addr_i == OFS_SEC);
  assign restart = wr_ctrl && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (wr_ctrl) en_q <= wdata_i[0];
    else if (expire)  en_q <= 1'b0;
  end

  wdt_tick_gen #(.CLK_PER_SEC(CLK_PER_SEC)) u_tick (
    .clk_i, .rst_ni,
    .run_i     (en_q),
    .restart_i (restart),
    .tick_o    (tick)
  );

  wdt_mmss_cnt #(.INIT_MIN(INIT_MIN), .INIT_SEC(INIT_SEC)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i   (tick),
    .wr_min_i (wr_min),
    .wr_sec_i (wr_sec),
    .wdata_i  (wdata_i),
    .min_o    (min_val),
    .sec_o    (sec_val),
    .expire_o (expire)
  );

  wdt_rst_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i, .rst_ni,
    .fire_i (expire),
    .rst_o  (wdt_rst_o)
  );

  assign tag_ofs = addr_i - OFS_TAG;

  always_comb begin
    rmux = 8'h00;
    if (addr_i == OFS_CTRL)         rmux = {7'b0, en_q};
    else if (addr_i == OFS_MIN)     rmux = min_val;
    else if (addr_i == OFS_SEC)     rmux = sec_val;
    else if (tag_ofs < 8'(TAG_LEN)) rmux = tag_byte(tag_ofs[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mmss_watchdog_chk.sv
module mmss_watchdog_chk #(
  parameter int unsigned RST_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       wdt_rst_o,
  input logic       en,
  input logic       tick,
  input logic [7:0] min_v,
  input logic [7:0] sec_v
);
  logic [15:0] total;
  logic        tw;
  logic [31:0] hi_cnt;

  assign total = 16'(min_v) * 16'd60 + 16'(sec_v);
  assign tw    = wr_i && (addr_i == 8'h07 || addr_i == 8'h08);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= '0;
  end

  AST_SEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_v <= 8'd59);  // R3
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));  // R4
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !tw && total != 16'd0) |=> (total == $past(total) - 16'd1));  // R5
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !tw) |=> $stable(total));  // R6
  AST_FIRE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> !en);  // R7
  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_rst_o) |-> (hi_cnt == 32'(RST_CYC)));  // R7
endmodule

bind mmss_watchdog mmss_watchdog_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .wdt_rst_o (wdt_rst_o),
  .en        (en_q),
  .tick      (tick),
  .min_v     (min_val),
  .sec_v     (sec_val)
);

// File: tb/mmss_watchdog_test.sv
module mmss_watchdog_test;
  localparam int unsigned P  = 4;
  localparam int unsigned RC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       wdt_rst;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit rst_seen = 0;

  always #10 clk = ~clk;

  mmss_watchdog #(.CLK_PER_SEC(P), .RST_CYC(RC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    if (wdt_rst) rst_seen = 1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    step();
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic bit mapped(input int a);
    return (a == 6 || a == 7 || a == 8 || (a >= 8'h4D && a <= 8'h4F));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int e0, n;
    int ts[8] = '{1, 2, 3, 59, 60, 61, 121, 0};

    repeat (3) @(negedge clk);
    chk("R1 rst_o", wdt_rst, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rreg(8'h06, v); chk("R1 ctrl", v, 0);
    rreg(8'h07, v); chk("R1 min", v, 1);
    rreg(8'h08, v); chk("R1 sec", v, 0);

    // R4: rdata holds when rd low
    addr = 8'h4D; step(); chk("R4 hold", rdata, 0);

    // R9 tag bytes and write immunity
    rreg(8'h4D, v); chk("R9 P", v, 8'h50);
    rreg(8'h4E, v); chk("R9 W", v, 8'h57);
    rreg(8'h4F, v); chk("R9 G", v, 8'h47);
    for (int a = 8'h4D; a <= 8'h4F; a++) wreg(8'(a), 8'hFF);
    rreg(8'h4D, v); chk("R9 ro P", v, 8'h50);
    rreg(8'h4F, v); chk("R9 ro G", v, 8'h47);

    // R10 unmapped sweep: writes ignored, reads zero
    for (int a = 0; a < 256; a++) if (!mapped(a)) wreg(8'(a), 8'hFF);
    for (int a = 0; a < 256; a++) if (!mapped(a)) begin
      rreg(8'(a), v); chk("R10 unmapped", v, 0);
    end
    rreg(8'h06, v); chk("R10 ctrl", v, 0);
    rreg(8'h07, v); chk("R10 min", v, 1);
    rreg(8'h08, v); chk("R10 sec", v, 0);

    // R3 sweeps, timer stopped
    for (int d = 0; d < 256; d++) begin
      wreg(8'h08, 8'(d)); rreg(8'h08, v); chk("R3 sec clamp", v, (d > 59) ? 59 : d);
    end
    for (int d = 0; d < 256; d++) begin
      wreg(8'h07, 8'(d)); rreg(8'h07, v); chk("R3 min", v, d);
    end

    // R2 control readback, upper bits ignored
    wreg(8'h06, 8'hFE); rreg(8'h06, v); chk("R2 bit0 clear", v, 0);

    // R6 stopped hold
    wreg(8'h07, 8'd0); wreg(8'h08, 8'd5);
    rst_seen = 0;
    repeat (10 * P) step();
    rreg(8'h08, v); chk("R6 sec hold", v, 5);
    chk("R6 no rst", rst_seen, 0);

    // R5 countdown with borrow from 2:00
    wreg(8'h07, 8'd2); wreg(8'h08, 8'd0);
    wreg(8'h06, 8'h01); e0 = cyc;
    rreg(8'h06, v); chk("R2 run bit", v, 1);
    for (int k = 0; k < 4; k++) begin
      while (cyc - e0 < k * P + 1) step();
      rreg(8'h07, v); rreg(8'h08, v2);
      chk("R5 min", v, (120 - k) / 60);
      chk("R5 sec", v2, (120 - k) % 60);
    end

    // R6 stop mid-count
    wreg(8'h06, 8'h00);
    rreg(8'h08, v);
    rst_seen = 0;
    repeat (5 * P) step();
    rreg(8'h08, v2); chk("R6 stop hold", v2, v);
    chk("R6 stop no rst", rst_seen, 0);

    // R7 expiry timing sweep
    foreach (ts[i]) begin
      wreg(8'h07, 8'(ts[i] / 60)); wreg(8'h08, 8'(ts[i] % 60));
      wreg(8'h06, 8'h01); e0 = cyc;
      while (!wdt_rst && cyc - e0 < 1000) step();
      chk("R7 fire time", cyc - e0, ((ts[i] == 0) ? 1 : ts[i]) * P);
      n = 1;
      forever begin
        step();
        if (wdt_rst) n++; else break;
      end
      chk("R7 width", n, RC);
      rreg(8'h06, v); chk("R7 run cleared", v, 0);
    end

    // R8 keepalive
    wreg(8'h07, 8'd0); wreg(8'h08, 8'd3);
    wreg(8'h06, 8'h01); e0 = cyc;
    rst_seen = 0;
    while (cyc - e0 < 2 * P + 1) step();
    wreg(8'h07, 8'd0); wreg(8'h08, 8'd3);
    wreg(8'h06, 8'h01); e0 = cyc;
    chk("R8 no early rst", rst_seen, 0);
    while (!wdt_rst && cyc - e0 < 1000) step();
    chk("R8 restart time", cyc - e0, 3 * P);
    repeat (RC + 2) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule